// File: doc/BRIEF.md
# Power Mode Sequencing Controller

This block is the state machine that keeps track of a processor's operating power mode and drives the enables that the clock and supply logic around it consume. The mode is one of five: full performance, bypassed-PLL operation, core sleep, deep sleep and hibernation. Software changes the mode and the PLL settings through one-cycle write strobes. An external wake event and a reset event bring the controller out of the low-power modes. The controller judges every request against the present mode and the stored PLL settings. An illegal request leaves the mode as it is and raises a sticky error flag.

The outputs decode the current mode into six enables: PLL enable, PLL bypass select, core clock enable, system clock enable, core supply enable and pad tri-state. They also give the applied clock multiplier and the mode code. A new multiplier value is only staged when it is written, and it takes effect on the next entry into full-performance mode. With `OUT_REG=1` the six enables are registered and lag the mode code by one clock.

Top module: `pwr_mode_seq`

## Requirements
- R1: While `por_n` is low, and after it is released, the mode is FULL (code 0), the applied multiplier is `MULT_RST`, the error flag is 0, the stored PLL enable is 1 and the stored bypass bit is 0.
- R2: The enables follow the mode. The bits are {pll_en, bypass, cclk, sclk, vdd, tri}. FULL gives {1,0,1,1,1,0}. ACTIVE (code 1) gives {stored enable,1,1,1,1,0}. SLEEP (code 2) gives {1,stored bypass,0,1,1,0}. DEEP (code 3) gives {0,1,0,0,1,0}. HIBER (code 4) gives {0,1,0,0,0,1}.
- R3: In FULL or ACTIVE, `mode_d` codes 0 (FULL), 1 (ACTIVE), 2 (SLEEP) and 3 (DEEP) move the controller to that mode when legal. Requesting the current mode is legal and changes nothing.
- R4: When the stored PLL enable is 0, requests for FULL or SLEEP are rejected. A rejection keeps the mode and sets the error flag.
- R5: A PLL control write updates the stored enable and bypass bits in ACTIVE. In FULL it is accepted only if it keeps the PLL enabled; otherwise it is rejected.
- R6: In SLEEP, DEEP or HIBER, every mode, PLL control, multiplier or regulator write is rejected.
- R7: A wake event in SLEEP goes to ACTIVE when the stored bypass bit is 1 and to FULL when it is 0. In any other mode a wake event is ignored.
- R8: Only a reset event leaves DEEP. It goes to ACTIVE when the stored bypass bit is 1 and to FULL when it is 0, and it keeps the stored settings and the error flag. Any entry into FULL sets the stored PLL enable to 1.
- R9: In FULL or ACTIVE, a regulator write of 2'b00 enters HIBER. Any other regulator value has no effect.
- R10: Only a reset event leaves HIBER. It goes to FULL with every stored setting back at its default and the error flag cleared.
- R11: An accepted multiplier write only stages the value. The applied multiplier takes the staged value on each transition into FULL from another mode.
- R12: A reset event in FULL, ACTIVE or SLEEP reinitialises the controller to the R1 state.
- R13: Mode request codes 4 to 7 are rejected.
- R14: The error flag stays set until a reset event outside DEEP or a low `por_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| rst_evt | input | 1 | Reset event used to leave deep sleep and hibernation |
| wake | input | 1 | Wake event for sleep mode |
| pll_we | input | 1 | PLL control write strobe |
| pll_en_d | input | 1 | PLL enable value written |
| pll_byp_d | input | 1 | PLL bypass value written |
| mult_we | input | 1 | Multiplier write strobe |
| mult_d | input | MULT_W | Multiplier value written |
| vreg_we | input | 1 | Regulator field write strobe |
| vreg_freq_d | input | 2 | Regulator frequency field; 2'b00 requests hibernation |
| mode_we | input | 1 | Mode request strobe |
| mode_d | input | 3 | Requested mode code |
| pll_en_o | output | 1 | PLL enable |
| pll_bypass_o | output | 1 | PLL bypass select |
| cclk_en_o | output | 1 | Core clock enable |
| sclk_en_o | output | 1 | System clock enable |
| core_vdd_en_o | output | 1 | Core supply enable |
| pad_tristate_o | output | 1 | Tri-state all external pads |
| mult_o | output | MULT_W | Applied clock multiplier |
| mode_o | output | 3 | Current mode code |
| err_o | output | 1 | Sticky rejected-request flag |

## Verification
The bench builds the block with `MULT_W=6`, `MULT_RST=10` and `OUT_REG=1`. It therefore checks the registered-output variant, whose enables lag the mode code by one clock. The 6-bit multiplier leaves room for staged values that clearly differ from the default, so an early or missed application of the staged value shows up. Random sequences walk every mode pair, including paths through ACTIVE with the PLL disabled into DEEP and back to FULL.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;

   typedef enum logic [2:0] {
      PM_FULL   = 3'd0,
      PM_ACTIVE = 3'd1,
      PM_SLEEP  = 3'd2,
      PM_DEEP   = 3'd3,
      PM_HIBER  = 3'd4
   } pm_state_e;

   typedef struct packed {
      logic pll_en;
      logic bypass;
      logic cclk_en;
      logic sclk_en;
      logic vdd_en;
      logic pad_tri;
   } pm_ctl_s;

   localparam pm_ctl_s PM_CTL_RESET = '{pll_en: 1'b1, bypass: 1'b0, cclk_en: 1'b1,
                                        sclk_en: 1'b1, vdd_en: 1'b1, pad_tri: 1'b0};

   // Decode of mode plus stored PLL settings into the control outputs
   function automatic pm_ctl_s pm_decode(pm_state_e st, logic pll_q, logic byp_q);
      pm_ctl_s c;
      c = PM_CTL_RESET;
      unique case (st)
         PM_FULL: c = PM_CTL_RESET;
         PM_ACTIVE: begin
            c.pll_en = pll_q;
            c.bypass = 1'b1;
         end
         PM_SLEEP: begin
            c.pll_en  = 1'b1;
            c.bypass  = byp_q;
            c.cclk_en = 1'b0;
         end
         PM_DEEP: begin
            c.pll_en  = 1'b0;
            c.bypass  = 1'b1;
            c.cclk_en = 1'b0;
            c.sclk_en = 1'b0;
         end
         default: begin
            c.pll_en  = 1'b0;
            c.bypass  = 1'b1;
            c.cclk_en = 1'b0;
            c.sclk_en = 1'b0;
            c.vdd_en  = 1'b0;
            c.pad_tri = 1'b1;
         end
      endcase
      return c;
   endfunction

   function automatic logic pm_awake(pm_state_e st);
      return (st == PM_FULL) || (st == PM_ACTIVE);
   endfunction

endpackage

// File: rtl/pwr_mode_fsm.sv
module pwr_mode_fsm
   import pwr_mode_pkg::*;
(
   input  logic       clk,
   input  logic       por_n,
   input  logic       rst_evt,
   input  logic       wake,
   input  logic       vreg_we,
   input  logic [1:0] vreg_freq_d,
   input  logic       mode_we,
   input  logic [2:0] mode_d,
   input  logic       pll_en_q,
   input  logic       byp_q,
   output pm_state_e  state_q,
   output pm_state_e  state_d,
   output logic       soft_rst,
   output logic       fsm_rej
);

   logic      awake;
   logic      req_ok;
   pm_state_e req_st;
   pm_state_e exit_st;

   assign awake   = pm_awake(state_q);
   assign exit_st = byp_q ? PM_ACTIVE : PM_FULL;

   // Legality of a mode request, judged from the current stored PLL state
   always_comb begin
      req_ok = 1'b0;
      req_st = state_q;
      unique case (mode_d)
         3'd0: begin
            req_st = PM_FULL;
            req_ok = pll_en_q;
         end
         3'd1: begin
            req_st = PM_ACTIVE;
            req_ok = 1'b1;
         end
         3'd2: begin
            req_st = PM_SLEEP;
            req_ok = pll_en_q;
         end
         3'd3: begin
            req_st = PM_DEEP;
            req_ok = 1'b1;
         end
         default: begin
            req_st = state_q;
            req_ok = 1'b0;
         end
      endcase
   end

   always_comb begin
      state_d  = state_q;
      soft_rst = 1'b0;
      fsm_rej  = 1'b0;
      if (rst_evt) begin
         if (state_q == PM_DEEP) begin
            state_d = exit_st;
         end else begin
            state_d  = PM_FULL;
            soft_rst = 1'b1;
         end
      end else if (!awake) begin
         if (state_q == PM_SLEEP && wake) begin
            state_d = exit_st;
         end
         fsm_rej = vreg_we | mode_we;
      end else if (vreg_we && vreg_freq_d == 2'b00) begin
         state_d = PM_HIBER;
      end else if (mode_we) begin
         if (req_ok) begin
            state_d = req_st;
         end else begin
            fsm_rej = 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         state_q <= PM_FULL;
      end else begin
         state_q <= state_d;
      end
   end

endmodule

// File: rtl/pwr_mode_regs.sv
module pwr_mode_regs
   import pwr_mode_pkg::*;
#(
   parameter int unsigned MULT_W   = 6,
   parameter int unsigned MULT_RST = 10
)(
   input  logic              clk,
   input  logic              por_n,
   input  logic              rst_evt,
   input  logic              soft_rst,
   input  logic              fsm_rej,
   input  pm_state_e         state_q,
   input  pm_state_e         state_d,
   input  logic              pll_we,
   input  logic              pll_en_d,
   input  logic              pll_byp_d,
   input  logic              mult_we,
   input  logic [MULT_W-1:0] mult_d,
   output logic              pll_en_q,
   output logic              byp_q,
   output logic [MULT_W-1:0] mult_q,
   output logic              err_q
);

   localparam logic [MULT_W-1:0] MULT_DEF = MULT_W'(MULT_RST);

   logic              wr_ok;
   logic              pll_acc;
   logic              pll_rej;
   logic              mult_rej;
   logic              enter_full;
   logic [MULT_W-1:0] mult_pend_q;

   assign wr_ok      = pm_awake(state_q) && !rst_evt;
   // PLL may only be switched off while the clocks are bypassed
   assign pll_acc    = wr_ok && pll_we && ((state_q == PM_ACTIVE) || pll_en_d);
   assign pll_rej    = pll_we && !rst_evt && !pll_acc;
   assign mult_rej   = mult_we && !rst_evt && !wr_ok;
   assign enter_full = (state_d == PM_FULL) && (state_q != PM_FULL);

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         pll_en_q    <= 1'b1;
         byp_q       <= 1'b0;
         mult_q      <= MULT_DEF;
         mult_pend_q <= MULT_DEF;
         err_q       <= 1'b0;
      end else if (soft_rst) begin
         pll_en_q    <= 1'b1;
         byp_q       <= 1'b0;
         mult_q      <= MULT_DEF;
         mult_pend_q <= MULT_DEF;
         err_q       <= 1'b0;
      end else begin
         if (pll_acc) begin
            pll_en_q <= pll_en_d;
            byp_q    <= pll_byp_d;
         end
         if (state_d == PM_FULL) begin
            pll_en_q <= 1'b1;
         end
         if (wr_ok && mult_we) begin
            mult_pend_q <= mult_d;
         end
         if (enter_full) begin
            mult_q <= mult_pend_q;
         end
         if (fsm_rej || pll_rej || mult_rej) begin
            err_q <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/pwr_mode_outdec.sv
module pwr_mode_outdec
   import pwr_mode_pkg::*;
#(
   parameter bit OUT_REG = 1'b1
)(
   input  logic      clk,
   input  logic      por_n,
   input  pm_state_e state_q,
   input  logic      pll_en_q,
   input  logic      byp_q,
   output pm_ctl_s   ctl_o
);

   pm_ctl_s ctl_c;

   assign ctl_c = pm_decode(state_q, pll_en_q, byp_q);

   generate
      if (OUT_REG) begin : g_reg
         pm_ctl_s ctl_q;
         always_ff @(posedge clk or negedge por_n) begin
            if (!por_n) begin
               ctl_q <= PM_CTL_RESET;
            end else begin
               ctl_q <= ctl_c;
            end
         end
         assign ctl_o = ctl_q;
      end else begin : g_comb
         logic unused_clk;
         assign unused_clk = clk ^ por_n;
         assign ctl_o = ctl_c;
      end
   endgenerate

endmodule

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq
   import pwr_mode_pkg::*;
#(
   parameter int unsigned MULT_W   = 6,
   parameter int unsigned MULT_RST = 10,
   parameter bit          OUT_REG  = 1'b1
)(
   input  logic              clk,
   input  logic              por_n,
   input  logic              rst_evt,
   input  logic              wake,
   input  logic              pll_we,
   input  logic              pll_en_d,
   input  logic              pll_byp_d,
   input  logic              mult_we,
   input  logic [MULT_W-1:0] mult_d,
   input  logic              vreg_we,
   input  logic [1:0]        vreg_freq_d,
   input  logic              mode_we,
   input  logic [2:0]        mode_d,
   output logic              pll_en_o,
   output logic              pll_bypass_o,
   output logic              cclk_en_o,
   output logic              sclk_en_o,
   output logic              core_vdd_en_o,
   output logic              pad_tristate_o,
   output logic [MULT_W-1:0] mult_o,
   output logic [2:0]        mode_o,
   output logic              err_o
);

   localparam int unsigned MULT_MAX = (1 << MULT_W) - 1;

   generate
      if (MULT_W < 1 || MULT_W > 16) begin : g_bad_width
         $error("pwr_mode_seq: MULT_W out of range");
      end
      if (MULT_RST > MULT_MAX) begin : g_bad_rst
         $error("pwr_mode_seq: MULT_RST does not fit MULT_W");
      end
   endgenerate

   pm_state_e state_q;
   pm_state_e state_d;
   logic      soft_rst;
   logic      fsm_rej;
   logic      pll_en_q;
   logic      byp_q;
   pm_ctl_s   ctl;

   pwr_mode_fsm u_fsm (
      .clk        (clk),
      .por_n      (por_n),
      .rst_evt    (rst_evt),
      .wake       (wake),
      .vreg_we    (vreg_we),
      .vreg_freq_d(vreg_freq_d),
      .mode_we    (mode_we),
      .mode_d     (mode_d),
      .pll_en_q   (pll_en_q),
      .byp_q      (byp_q),
      .state_q    (state_q),
      .state_d    (state_d),
      .soft_rst   (soft_rst),
      .fsm_rej    (fsm_rej)
   );

   pwr_mode_regs #(
      .MULT_W  (MULT_W),
      .MULT_RST(MULT_RST)
   ) u_regs (
      .clk      (clk),
      .por_n    (por_n),
      .rst_evt  (rst_evt),
      .soft_rst (soft_rst),
      .fsm_rej  (fsm_rej),
      .state_q  (state_q),
      .state_d  (state_d),
      .pll_we   (pll_we),
      .pll_en_d (pll_en_d),
      .pll_byp_d(pll_byp_d),
      .mult_we  (mult_we),
      .mult_d   (mult_d),
      .pll_en_q (pll_en_q),
      .byp_q    (byp_q),
      .mult_q   (mult_o),
      .err_q    (err_o)
   );

   pwr_mode_outdec #(
      .OUT_REG(OUT_REG)
   ) u_outdec (
      .clk     (clk),
      .por_n   (por_n),
      .state_q (state_q),
      .pll_en_q(pll_en_q),
      .byp_q   (byp_q),
      .ctl_o   (ctl)
   );

   assign mode_o         = state_q;
   assign pll_en_o       = ctl.pll_en;
   assign pll_bypass_o   = ctl.bypass;
   assign cclk_en_o      = ctl.cclk_en;
   assign sclk_en_o      = ctl.sclk_en;
   assign core_vdd_en_o  = ctl.vdd_en;
   assign pad_tristate_o = ctl.pad_tri;

endmodule

// File: rtl/pwr_mode_seq_chk.sv
module pwr_mode_seq_chk #(
   parameter int unsigned MULT_W = 6
)(
   input logic              clk,
   input logic              por_n,
   input logic              rst_evt,
   input logic              pll_en_o,
   input logic              pll_bypass_o,
   input logic              cclk_en_o,
   input logic              sclk_en_o,
   input logic              core_vdd_en_o,
   input logic              pad_tristate_o,
   input logic [MULT_W-1:0] mult_o,
   input logic [2:0]        mode_o,
   input logic              err_o
);

   // R2: the core clock never runs while the system clock is stopped
   p_cclk_needs_sclk_r2: assert property (@(posedge clk) disable iff (!por_n)
      cclk_en_o |-> sclk_en_o);

   // R2: an unbypassed running core needs a running PLL
   p_clk_source_r2: assert property (@(posedge clk) disable iff (!por_n)
      (cclk_en_o && !pll_bypass_o) |-> pll_en_o);

   // R10: pads float only while the core supply is off
   p_tri_vdd_r10: assert property (@(posedge clk) disable iff (!por_n)
      pad_tristate_o |-> !core_vdd_en_o);

   // R8: deep sleep is held until a reset event
   p_deep_hold_r8: assert property (@(posedge clk) disable iff (!por_n)
      (mode_o == 3'd3 && !rst_evt) |=> (mode_o == 3'd3));

   // R10: hibernation is held until a reset event
   p_hib_hold_r10: assert property (@(posedge clk) disable iff (!por_n)
      (mode_o == 3'd4 && !rst_evt) |=> (mode_o == 3'd4));

   // R14: the error flag is sticky between reset events
   p_err_sticky_r14: assert property (@(posedge clk) disable iff (!por_n)
      (err_o && !rst_evt) |=> err_o);

   // R11: the applied multiplier moves only on entry to full mode
   p_mult_entry_r11: assert property (@(posedge clk) disable iff (!por_n)
      !rst_evt |=> ($stable(mult_o) || (mode_o == 3'd0 && $past(mode_o) != 3'd0)));

   // R3: mode code stays within the five defined modes
   p_mode_range_r3: assert property (@(posedge clk) disable iff (!por_n)
      mode_o <= 3'd4);

endmodule

bind pwr_mode_seq pwr_mode_seq_chk #(.MULT_W(MULT_W)) u_chk (
   .clk           (clk),
   .por_n         (por_n),
   .rst_evt       (rst_evt),
   .pll_en_o      (pll_en_o),
   .pll_bypass_o  (pll_bypass_o),
   .cclk_en_o     (cclk_en_o),
   .sclk_en_o     (sclk_en_o),
   .core_vdd_en_o (core_vdd_en_o),
   .pad_tristate_o(pad_tristate_o),
   .mult_o        (mult_o),
   .mode_o        (mode_o),
   .err_o         (err_o)
);

// File: tb/pwr_mode_seq_tb.sv
module pwr_mode_seq_tb;

   localparam int MULT_W   = 6;
   localparam int MULT_RST = 10;
   localparam int OP_MODE = 0, OP_PLL = 1, OP_MULT = 2, OP_VREG = 3, OP_WAKE = 4, OP_RST = 5;
   localparam int S_FULL = 0, S_ACT = 1, S_SLEEP = 2, S_DEEP = 3, S_HIB = 4;

   logic              clk = 1'b0;
   logic              por_n = 1'b0;
   logic              rst_evt = 1'b0, wake = 1'b0;
   logic              pll_we = 1'b0, pll_en_d = 1'b0, pll_byp_d = 1'b0;
   logic              mult_we = 1'b0;
   logic [MULT_W-1:0] mult_d = '0;
   logic              vreg_we = 1'b0;
   logic [1:0]        vreg_freq_d = 2'b00;
   logic              mode_we = 1'b0;
   logic [2:0]        mode_d = 3'd0;
   logic              pll_en_o, pll_bypass_o, cclk_en_o, sclk_en_o, core_vdd_en_o, pad_tristate_o;
   logic [MULT_W-1:0] mult_o;
   logic [2:0]        mode_o;
   logic              err_o;

   int checks = 0, failures = 0;
   bit done = 1'b0;

   // reference model state
   int m_st, m_mult, m_pend;
   bit m_pll, m_byp, m_err;

   always #10 clk = ~clk;

   pwr_mode_seq #(.MULT_W(MULT_W), .MULT_RST(MULT_RST), .OUT_REG(1'b1)) u_dut (
      .clk(clk), .por_n(por_n), .rst_evt(rst_evt), .wake(wake),
      .pll_we(pll_we), .pll_en_d(pll_en_d), .pll_byp_d(pll_byp_d),
      .mult_we(mult_we), .mult_d(mult_d), .vreg_we(vreg_we), .vreg_freq_d(vreg_freq_d),
      .mode_we(mode_we), .mode_d(mode_d),
      .pll_en_o(pll_en_o), .pll_bypass_o(pll_bypass_o), .cclk_en_o(cclk_en_o),
      .sclk_en_o(sclk_en_o), .core_vdd_en_o(core_vdd_en_o), .pad_tristate_o(pad_tristate_o),
      .mult_o(mult_o), .mode_o(mode_o), .err_o(err_o)
   );

   task automatic chk(string req, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // {pll_en, bypass, cclk, sclk, vdd, tri} per mode, from R2
   function automatic logic [5:0] exp_ctl(int st, bit pll, bit byp);
      case (st)
         S_FULL:  return 6'b101110;
         S_ACT:   return {pll, 5'b11110};
         S_SLEEP: return {1'b1, byp, 4'b0110};
         S_DEEP:  return 6'b010010;
         default: return 6'b010001;
      endcase
   endfunction

   function automatic bit awake(int st);
      return (st == S_FULL) || (st == S_ACT);
   endfunction

   task automatic model_defaults();
      m_st = S_FULL; m_pll = 1'b1; m_byp = 1'b0; m_err = 1'b0;
      m_mult = MULT_RST; m_pend = MULT_RST;
   endtask

   task automatic model_goto(int nst);
      if (nst == S_FULL) begin
         m_pll = 1'b1;
         if (m_st != S_FULL) m_mult = m_pend;
      end
      m_st = nst;
   endtask

   task automatic model_op(int op, int a, int b);
      case (op)
         OP_RST: if (m_st == S_DEEP) model_goto(m_byp ? S_ACT : S_FULL);   // R8
                 else model_defaults();                                    // R10 R12
         OP_WAKE: if (m_st == S_SLEEP) model_goto(m_byp ? S_ACT : S_FULL); // R7
         OP_VREG: if (!awake(m_st)) m_err = 1'b1;
                  else if (a == 0) m_st = S_HIB;                           // R9
         OP_MULT: if (!awake(m_st)) m_err = 1'b1; else m_pend = a;         // R11
         OP_PLL: if (awake(m_st) && (m_st == S_ACT || a != 0)) begin       // R5
                    m_pll = bit'(a); m_byp = bit'(b);
                 end else m_err = 1'b1;
         default: begin
            bit ok;
            if (!awake(m_st)) ok = 1'b0;                                   // R6
            else if (a == 0 || a == 2) ok = m_pll;                         // R4
            else ok = (a == 1 || a == 3);                                  // R13
            if (ok) model_goto(a); else m_err = 1'b1;
         end
      endcase
   endtask

   task automatic check_all(string req);
      logic [5:0] e;
      e = exp_ctl(m_st, m_pll, m_byp);
      chk(req, "mode_o", int'(mode_o), m_st);
      chk(req, "pll_en_o", int'(pll_en_o), int'(e[5]));
      chk(req, "pll_bypass_o", int'(pll_bypass_o), int'(e[4]));
      chk(req, "cclk_en_o", int'(cclk_en_o), int'(e[3]));
      chk(req, "sclk_en_o", int'(sclk_en_o), int'(e[2]));
      chk(req, "core_vdd_en_o", int'(core_vdd_en_o), int'(e[1]));
      chk(req, "pad_tristate_o", int'(pad_tristate_o), int'(e[0]));
      chk(req, "mult_o", int'(mult_o), m_mult);
      chk(req, "err_o", int'(err_o), int'(m_err));
   endtask

   task automatic do_op(int op, int a, int b, string req);
      @(negedge clk);
      case (op)
         OP_MODE: begin mode_we = 1'b1; mode_d = 3'(a); end
         OP_PLL:  begin pll_we = 1'b1; pll_en_d = a[0]; pll_byp_d = b[0]; end
         OP_MULT: begin mult_we = 1'b1; mult_d = MULT_W'(a); end
         OP_VREG: begin vreg_we = 1'b1; vreg_freq_d = 2'(a); end
         OP_WAKE: wake = 1'b1;
         default: rst_evt = 1'b1;
      endcase
      model_op(op, a, b);
      @(negedge clk);
      mode_we = 1'b0; pll_we = 1'b0; mult_we = 1'b0; vreg_we = 1'b0;
      wake = 1'b0; rst_evt = 1'b0;
      @(negedge clk);
      check_all(req);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h0051_ee70));
      model_defaults();
      repeat (3) @(negedge clk);
      check_all("R1");
      por_n = 1'b1;
      @(negedge clk);
      check_all("R1");

      // R11: staging and application on entry to full mode
      do_op(OP_MULT, 20, 0, "R11");
      do_op(OP_MODE, 1, 0, "R11");
      do_op(OP_MULT, 33, 0, "R11");
      do_op(OP_MODE, 0, 0, "R11");
      // R5: disabling the PLL in full mode is rejected; R14 sticky; R12 clears
      do_op(OP_PLL, 0, 1, "R5");
      do_op(OP_MODE, 1, 0, "R14");
      do_op(OP_RST, 0, 0, "R12");
      // R4: disabled PLL in active blocks full and sleep
      do_op(OP_MODE, 1, 0, "R3");
      do_op(OP_PLL, 0, 1, "R5");
      do_op(OP_MODE, 0, 0, "R4");
      do_op(OP_MODE, 2, 0, "R4");
      do_op(OP_PLL, 1, 1, "R5");
      do_op(OP_MODE, 2, 0, "R3");
      do_op(OP_MODE, 1, 0, "R6");
      do_op(OP_MULT, 7, 0, "R6");
      do_op(OP_WAKE, 0, 0, "R7");
      do_op(OP_PLL, 1, 0, "R5");
      do_op(OP_MODE, 2, 0, "R3");
      do_op(OP_WAKE, 0, 0, "R7");
      do_op(OP_WAKE, 0, 0, "R7");
      // R8: deep sleep exits
      do_op(OP_MODE, 3, 0, "R3");
      do_op(OP_WAKE, 0, 0, "R8");
      do_op(OP_PLL, 1, 1, "R6");
      do_op(OP_RST, 0, 0, "R8");
      do_op(OP_MODE, 1, 0, "R3");
      do_op(OP_PLL, 0, 0, "R5");
      do_op(OP_MODE, 3, 0, "R3");
      do_op(OP_RST, 0, 0, "R8");
      do_op(OP_MODE, 5, 0, "R13");
      do_op(OP_MODE, 7, 0, "R13");
      // R9/R10: regulator field and hibernation
      do_op(OP_VREG, 1, 0, "R9");
      do_op(OP_VREG, 3, 0, "R9");
      do_op(OP_VREG, 0, 0, "R9");
      do_op(OP_WAKE, 0, 0, "R10");
      do_op(OP_MODE, 0, 0, "R10");
      do_op(OP_RST, 0, 0, "R10");

      for (int i = 0; i < 1500; i++) begin
         int r;
         int op;
         r = int'($urandom_range(0, 99));
         if (r < 35) op = OP_MODE;
         else if (r < 55) op = OP_PLL;
         else if (r < 70) op = OP_MULT;
         else if (r < 78) op = OP_VREG;
         else if (r < 91) op = OP_WAKE;
         else op = OP_RST;
         case (op)
            OP_MODE: do_op(op, int'($urandom_range(0, 7)), 0, "R3");
            OP_PLL:  do_op(op, int'($urandom_range(0, 1)), int'($urandom_range(0, 1)), "R5");
            OP_MULT: do_op(op, int'($urandom_range(0, (1 << MULT_W) - 1)), 0, "R11");
            OP_VREG: do_op(op, int'($urandom_range(0, 3)), 0, "R9");
            OP_WAKE: do_op(op, 0, 0, "R7");
            default: do_op(op, 0, 0, "R8");
         endcase
      end

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule